// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block owns the processor's current status word and five banked saved-status words. It also decides where the program counter goes when an exception is taken or a handler returns. Six request lines (undefined instruction, software interrupt, prefetch abort, data abort, IRQ, FIQ) and the reset input are arbitrated each cycle.

When a request wins arbitration, the block does the following on the same clock edge:
- copies the old status into the saved-status word of the target mode;
- switches the mode field;
- sets the interrupt masks;
- clears the instruction-state flag;
- emits a link write carrying the current program counter for the target mode's register 14;
- emits a program-counter redirect to that exception's vector.

A return strobe restores the status from the current mode's saved word and redirects to the supplied link value. A status-write port lets the surrounding pipeline update flags or change mode. Every output is registered, so each action appears on the ports one cycle after the edge that sampled it.

Top module: `exc_ctrl`

## Requirements
- R1: While `rst_n` is low, the block does the following: `status` = 0x000000D3 (supervisor mode 0x13, bit 7 and bit 6 set), every saved-status word = 0, `redir_vld` = 1 with `redir_pc` = `VEC_BASE`, and `lnk_we` = `ret_err` = 0.
- R2: Status layout is fixed. Bits 31..27 are the N, Z, C, V and Q flags, bits 26..8 always read zero, bit 7 is the IRQ mask, bit 6 the FIQ mask, bit 5 the instruction-state flag and bits 4..0 the mode. A `st_we` write loads `st_wdata` ANDed with 0xF80000FF.
- R3: Each exception maps to a target mode and a vector offset added to `VEC_BASE`:
  - undefined → mode 0x1B, offset 0x04;
  - software interrupt → 0x13, offset 0x08;
  - prefetch abort → 0x17, offset 0x0C;
  - data abort → 0x17, offset 0x10;
  - IRQ → 0x12, offset 0x18;
  - FIQ → 0x11, offset 0x1C.

  One cycle after the sampling edge, `redir_vld` = 1 and `redir_pc` holds the vector.
- R4: On entry, bits 4..0 take the target mode, bit 7 is set, bit 5 is cleared, and bits 31..27 and bit 6 (except as in R5) keep their old values.
- R5: Bit 6 is set on entry only for FIQ (and by reset); every other entry leaves it unchanged.
- R6: On entry, `lnk_we` pulses for one cycle with `lnk_mode` = target mode and `lnk_data` = `cur_pc`. The target mode's saved-status word receives the status held before entry, which is visible on `spsr_cur`.
- R7: Simultaneous requests are served in this order: data abort, then FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R8: An IRQ request is ignored while status bit 7 is set. An FIQ request is ignored while bit 6 is set. No entry occurs, and a lower-priority unmasked request is taken instead.
- R9: A `ret_req` in a mode with a saved-status word (0x11, 0x12, 0x13, 0x17, 0x1B) does two things one cycle later. It loads the status from that word, and it gives `redir_vld` = 1 with `redir_pc` = `lr_val`.
- R10: A `ret_req` in any other mode (user 0x10, system 0x1F) leaves the status unchanged, produces no redirect, and pulses `ret_err` for one cycle. `spsr_cur` reads 0 in such modes.
- R11: In one cycle, an accepted exception takes precedence over `ret_req`, and both take precedence over `st_we`. The losing inputs have no effect.
- R12: Each of the five modes with saved status keeps its own saved-status word, so nested entries return in reverse order to the correct status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; acts as the reset exception |
| req_undef | input | 1 | Undefined-instruction request |
| req_swi | input | 1 | Software-interrupt request |
| req_pabt | input | 1 | Prefetch-abort request |
| req_dabt | input | 1 | Data-abort request |
| req_irq | input | 1 | Interrupt request line |
| req_fiq | input | 1 | Fast interrupt request line |
| cur_pc | input | AW | Return link for an exception taken this cycle |
| ret_req | input | 1 | Return-from-exception strobe |
| lr_val | input | AW | Link value of the current mode for a return |
| st_we | input | 1 | Status write enable |
| st_wdata | input | 32 | Status write data |
| status | output | 32 | Current status word |
| spsr_cur | output | 32 | Saved-status word of the current mode (0 if none) |
| redir_vld | output | 1 | Program-counter redirect valid |
| redir_pc | output | AW | New program counter |
| lnk_we | output | 1 | Link-register write strobe |
| lnk_mode | output | 5 | Mode whose register 14 takes the link |
| lnk_data | output | AW | Link value to write |
| ret_err | output | 1 | Return requested in a mode without saved status |

## Verification
The entry path is tried with several request patterns:
- Each request alone, from mask-clear supervisor, user and system states. This separates the mode and vector maps.
- Requests with non-zero flags or the instruction-state bit set. These show which bits survive entry.
- Descending sets of simultaneous requests. These pin each step of the priority chain.

Masked IRQ and FIQ requests, alone and paired with another request, separate true masking from plain priority. The return path is tried in two ways:
- From nested IRQ-then-FIQ entries, which only pass if the saved words are banked per mode.
- From user and system modes, plus same-cycle collisions of entry, return and status write, which tell the precedence rules apart.

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_undef,
  input  logic          req_swi,
  input  logic          req_pabt,
  input  logic          req_dabt,
  input  logic          req_irq,
  input  logic          req_fiq,
  input  logic [AW-1:0] cur_pc,
  input  logic          ret_req,
  input  logic [AW-1:0] lr_val,
  input  logic          st_we,
  input  logic [31:0]   st_wdata,
  output logic [31:0]   status,
  output logic [31:0]   spsr_cur,
  output logic          redir_vld,
  output logic [AW-1:0] redir_pc,
  output logic          lnk_we,
  output logic [4:0]    lnk_mode,
  output logic [AW-1:0] lnk_data,
  output logic          ret_err
);
  localparam logic [4:0]  M_FIQ = 5'h11;
  localparam logic [4:0]  M_IRQ = 5'h12;
  localparam logic [4:0]  M_SVC = 5'h13;
  localparam logic [4:0]  M_ABT = 5'h17;
  localparam logic [4:0]  M_UND = 5'h1B;
  localparam int          NBANK = 5;
  localparam logic [2:0]  NO_BANK = 3'd7;
  localparam logic [31:0] ST_MASK = 32'hF800_00FF;
  localparam logic [31:0] ST_RST  = {24'h0, 1'b1, 1'b1, 1'b0, M_SVC};

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   bank_of = 3'd0;
      M_IRQ:   bank_of = 3'd1;
      M_SVC:   bank_of = 3'd2;
      M_ABT:   bank_of = 3'd3;
      M_UND:   bank_of = 3'd4;
      default: bank_of = NO_BANK;
    endcase
  endfunction

  logic [31:0] st_q;
  logic [31:0] sv_q [NBANK];

  logic       take, set_f;
  logic [4:0] tgt, voff;
  logic [2:0] cur_bank, tgt_bank;
  logic       has_sv;

  wire irq_ok = req_irq & ~st_q[7];
  wire fiq_ok = req_fiq & ~st_q[6];

  always_comb begin
    take  = 1'b1;
    set_f = 1'b0;
    tgt   = M_SVC;
    voff  = 5'h00;
    if (req_dabt)       begin tgt = M_ABT; voff = 5'h10; end
    else if (fiq_ok)    begin tgt = M_FIQ; voff = 5'h1C; set_f = 1'b1; end
    else if (irq_ok)    begin tgt = M_IRQ; voff = 5'h18; end
    else if (req_pabt)  begin tgt = M_ABT; voff = 5'h0C; end
    else if (req_undef) begin tgt = M_UND; voff = 5'h04; end
    else if (req_swi)   begin tgt = M_SVC; voff = 5'h08; end
    else                take = 1'b0;
  end

  assign cur_bank = bank_of(st_q[4:0]);
  assign tgt_bank = bank_of(tgt);
  assign has_sv   = cur_bank != NO_BANK;
  assign spsr_cur = has_sv ? sv_q[cur_bank] : 32'h0;
  assign status   = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_RST;
      for (int b = 0; b < NBANK; b++) sv_q[b] <= '0;
      redir_vld <= 1'b1;
      redir_pc  <= VEC_BASE;
      lnk_we    <= 1'b0;
      lnk_mode  <= '0;
      lnk_data  <= '0;
      ret_err   <= 1'b0;
    end else begin
      redir_vld <= 1'b0;
      lnk_we    <= 1'b0;
      ret_err   <= 1'b0;
      if (take) begin
        sv_q[tgt_bank] <= st_q;
        st_q      <= {st_q[31:8], 1'b1, st_q[6] | set_f, 1'b0, tgt};
        redir_vld <= 1'b1;
        redir_pc  <= VEC_BASE + AW'(voff);
        lnk_we    <= 1'b1;
        lnk_mode  <= tgt;
        lnk_data  <= cur_pc;
      end else if (ret_req) begin
        if (has_sv) begin
          st_q      <= sv_q[cur_bank] & ST_MASK;
          redir_vld <= 1'b1;
          redir_pc  <= lr_val;
        end else begin
          ret_err <= 1'b1;
        end
      end else if (st_we) begin
        st_q <= st_wdata & ST_MASK;
      end
    end
  end
endmodule

module exc_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] status,
  input logic        redir_vld,
  input logic        lnk_we,
  input logic [4:0]  lnk_mode,
  input logic        ret_err
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[26:8] == 19'h0); // R2
  AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_we |-> (status[7] && !status[5] && status[4:0] == lnk_mode)); // R4
  AST_FIQ_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_we && lnk_mode == 5'h11) |-> status[6]); // R5
  AST_FIQ_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_we && lnk_mode != 5'h11) |-> status[6] == $past(status[6])); // R5
  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_we && lnk_mode == 5'h12) |-> !$past(status[7])); // R8
  AST_FIQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_we && lnk_mode == 5'h11) |-> !$past(status[6])); // R8
  AST_RET_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |-> (status == $past(status) && !redir_vld)); // R10
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(lnk_we && ret_err)); // R11
endmodule

bind exc_ctrl exc_ctrl_chk u_chk (.*);

// File: tb/sim_exc_ctrl.sv
module sim_exc_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_undef = 0, req_swi = 0, req_pabt = 0, req_dabt = 0, req_irq = 0, req_fiq = 0;
  logic [31:0] cur_pc = '0, lr_val = '0, st_wdata = '0;
  logic ret_req = 0, st_we = 0;
  logic [31:0] status, spsr_cur, redir_pc, lnk_data;
  logic redir_vld, lnk_we, ret_err;
  logic [4:0] lnk_mode;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exc_ctrl u0 (.*);

  localparam int NV = 17;
  // requests {dabt,fiq,irq,pabt,undef,swi}; vector 8'hFF = no entry expected
  localparam logic [31:0] V_ST [NV] = '{32'h13, 32'hF0000013, 32'h13, 32'h13, 32'h13, 32'h13, 32'h33,
    32'h93, 32'h53, 32'h53, 32'h13, 32'h13, 32'h13, 32'h13, 32'h13, 32'h10, 32'h1F};
  localparam logic [5:0] V_RQ [NV] = '{6'b000001, 6'b000010, 6'b000100, 6'b100000, 6'b001000, 6'b010000,
    6'b010000, 6'b001000, 6'b010000, 6'b011000, 6'b111111, 6'b011111, 6'b001111, 6'b000111,
    6'b000011, 6'b000001, 6'b001000};
  localparam logic [31:0] V_EX [NV] = '{32'h93, 32'hF000009B, 32'h97, 32'h97, 32'h92, 32'hD1, 32'hD1,
    32'h93, 32'h53, 32'hD2, 32'h97, 32'hD1, 32'h92, 32'h97, 32'h9B, 32'h93, 32'h92};
  localparam logic [7:0] V_VC [NV] = '{8'h08, 8'h04, 8'h0C, 8'h10, 8'h18, 8'h1C, 8'h1C,
    8'hFF, 8'hFF, 8'h18, 8'h10, 8'h1C, 8'h18, 8'h0C, 8'h04, 8'h08, 8'h18};

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr_st(input logic [31:0] v);
    st_we = 1; st_wdata = v; tick; st_we = 0;
  endtask

  task automatic do_ret(input logic [31:0] lr);
    ret_req = 1; lr_val = lr; tick; ret_req = 0;
  endtask

  function automatic logic [4:0] mode_of(input logic [7:0] vc);
    case (vc)
      8'h04: mode_of = 5'h1B;
      8'h08: mode_of = 5'h13;
      8'h0C, 8'h10: mode_of = 5'h17;
      8'h18: mode_of = 5'h12;
      default: mode_of = 5'h11;
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk); #1;
    chk("R1", "reset status", status, 32'hD3);
    chk("R1", "reset redir_vld", {31'h0, redir_vld}, 32'h1);
    chk("R1", "reset redir_pc", redir_pc, 32'h0);
    chk("R1", "reset lnk_we/ret_err", {30'h0, lnk_we, ret_err}, 32'h0);
    chk("R1", "reset spsr_cur", spsr_cur, 32'h0);
    rst_n = 1; tick;
    chk("R1", "redir drops after reset", {31'h0, redir_vld}, 32'h0);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      wr_st(V_ST[i]);
      {req_dabt, req_fiq, req_irq, req_pabt, req_undef, req_swi} = V_RQ[i];
      cur_pc = 32'h1000 + 32'(i) * 4;
      tick;
      {req_dabt, req_fiq, req_irq, req_pabt, req_undef, req_swi} = '0;
      chk("R4/R5/R7/R8", $sformatf("vec%0d status", i), status, V_EX[i]);
      if (V_VC[i] == 8'hFF) begin
        chk("R8", $sformatf("vec%0d masked, no redirect", i), {31'h0, redir_vld}, 32'h0);
        chk("R8", $sformatf("vec%0d masked, no link", i), {31'h0, lnk_we}, 32'h0);
      end else begin
        chk("R3", $sformatf("vec%0d redir_vld", i), {31'h0, redir_vld}, 32'h1);
        chk("R3", $sformatf("vec%0d redir_pc", i), redir_pc, {24'h0, V_VC[i]});
        chk("R6", $sformatf("vec%0d lnk_we", i), {31'h0, lnk_we}, 32'h1);
        chk("R6", $sformatf("vec%0d lnk_mode", i), {27'h0, lnk_mode}, {27'h0, mode_of(V_VC[i])});
        chk("R6", $sformatf("vec%0d lnk_data", i), lnk_data, cur_pc);
        chk("R6", $sformatf("vec%0d saved status", i), spsr_cur, V_ST[i]);
      end
    end

    // R2 layout, R10 return without saved status
    wr_st(32'hFFFF_FFFF);
    chk("R2", "reserved bits read zero", status, 32'hF800_00FF);
    chk("R10", "spsr_cur in system mode", spsr_cur, 32'h0);
    do_ret(32'h4444);
    chk("R10", "sys return error", {31'h0, ret_err}, 32'h1);
    chk("R10", "sys return no redirect", {31'h0, redir_vld}, 32'h0);
    chk("R10", "sys return status kept", status, 32'hF800_00FF);
    wr_st(32'h2000_0010);
    do_ret(32'h4444);
    chk("R10", "usr return error", {31'h0, ret_err}, 32'h1);
    chk("R10", "usr return status kept", status, 32'h2000_0010);
    tick;
    chk("R10", "ret_err is a pulse", {31'h0, ret_err}, 32'h0);

    // R9 R12 nested entries and returns
    wr_st(32'h6000_0013);
    req_irq = 1; cur_pc = 32'h100; tick; req_irq = 0;
    chk("R12", "irq entry status", status, 32'h6000_0092);
    wr_st(32'h8000_0012);
    req_fiq = 1; cur_pc = 32'h200; tick; req_fiq = 0;
    chk("R12", "fiq entry status", status, 32'h8000_00D1);
    chk("R12", "fiq saved status", spsr_cur, 32'h8000_0012);
    do_ret(32'h204);
    chk("R9", "fiq return status", status, 32'h8000_0012);
    chk("R9", "fiq return redir_pc", redir_pc, 32'h204);
    chk("R9", "fiq return redir_vld", {31'h0, redir_vld}, 32'h1);
    chk("R12", "irq bank intact", spsr_cur, 32'h6000_0013);
    do_ret(32'h104);
    chk("R9", "irq return status", status, 32'h6000_0013);
    chk("R9", "irq return redir_pc", redir_pc, 32'h104);

    // R11 collisions
    wr_st(32'h13);
    req_swi = 1; ret_req = 1; st_we = 1; st_wdata = 32'h10; cur_pc = 32'h300; tick;
    req_swi = 0; ret_req = 0; st_we = 0;
    chk("R11", "entry beats return/write", status, 32'h93);
    chk("R11", "entry link write", {31'h0, lnk_we}, 32'h1);
    chk("R11", "entry redir_pc", redir_pc, 32'h08);
    ret_req = 1; st_we = 1; st_wdata = 32'h1F; lr_val = 32'h304; tick;
    ret_req = 0; st_we = 0;
    chk("R11", "return beats write", status, 32'h13);
    chk("R11", "return redir_pc", redir_pc, 32'h304);

    // R1 reset mid-run
    wr_st(32'hF000_001F);
    rst_n = 0; #1;
    chk("R1", "async reset status", status, 32'hD3);
    chk("R1", "async reset redirect", {31'h0, redir_vld}, 32'h1);
    tick; rst_n = 1; tick;
    chk("R1", "banks cleared by reset", spsr_cur, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule